// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block keeps a handful of recent virtual-to-physical page translations so that most memory accesses skip the page table walk. A 32-bit virtual address is presented with a request strobe. The page number in the upper twenty bits is compared against every stored entry at once. On a hit the physical address (frame number with the page offset appended) comes out in the same cycle, together with the page's referenced and modified flags. On a miss the block raises a miss flag, and a page table walker outside this block fetches the translation from the in-memory tables.

The walker hands the result back through a fill port, and the block installs it. An existing entry for the same page is reused, then the lowest free slot, then a slot chosen by a rotating pointer. Each hit marks its page as referenced, and a hit on a store also marks it modified. A flush input drops every translation in a single cycle.

Top module: `tlb_fa`

## Requirements
- R1: The virtual page number is `lk_vaddr[31:12]`. On a hit, `lk_paddr` equals the stored frame number in bits 31:12 and `lk_vaddr[11:0]` in bits 11:0, in the same cycle as the request.
- R2: While `lk_req` is high, exactly one of `lk_hit` and `lk_miss` is high, and `lk_miss` is high when no valid entry holds the page number. While `lk_req` is low, both are low.
- R3: After reset no entry is valid, so every lookup misses.
- R4: A hit reports the referenced flag (`lk_ref`) as it stood before this access and sets that flag, so the next access to the same page reports 1.
- R5: A hit with `lk_store` high sets the page's modified flag, which `lk_dirty` reports from the next access on.
- R6: A fill installs the translation with referenced and modified flags at 0, and a lookup of that page hits from the next cycle.
- R7: Filling a page number that is already present overwrites that entry, clears its flags, and uses no other slot, so no two valid entries hold the same page number.
- R8: A fill of a new page while a slot is free goes to the lowest-numbered free slot and leaves every valid entry intact.
- R9: A fill of a new page while all slots are valid replaces the slot named by a rotating pointer. The pointer is 0 after reset or flush, advances by one on each such replacement, and wraps from the last slot to slot 0.
- R10: A flush invalidates every entry in one cycle and outranks a fill in the same cycle, whose page then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| lk_req | input | 1 | Lookup request |
| lk_store | input | 1 | Lookup is for a store (sets modified flag on hit) |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent, walk required |
| lk_paddr | output | 32 | Physical address on hit |
| lk_ref | output | 1 | Page referenced flag of the hit entry |
| lk_dirty | output | 1 | Page modified flag of the hit entry |
| fill_req | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Physical frame number to install |

## Verification
On every cycle the assertions check that hit and miss are mutually exclusive and follow the request strobe, that no two valid entries ever match the same page, that a flush leaves no valid entry behind, and that a hit sets the referenced flag and a store hit sets the modified flag of the entry that hit. Which slot a fill lands in, the rotating pointer's wrap, and the address concatenation can only be seen through the bench's scenarios. The bench fills the buffer, evicts through a full rotation, and looks for the page that should be gone and the pages that should remain.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int ADDR_W = 32;
    localparam int OFS_W  = 12;
    localparam int VPN_W  = ADDR_W - OFS_W;
    localparam int PFN_W  = 20;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PFN_W-1:0] pfn_t;
    typedef logic [OFS_W-1:0] ofs_t;

    typedef struct packed {
        logic valid;
        vpn_t vpn;
        pfn_t pfn;
        logic refd;
        logic dirty;
    } tlb_entry_t;

    function automatic logic [PFN_W+OFS_W-1:0] join_paddr(pfn_t pfn, ofs_t ofs);
        return {pfn, ofs};
    endfunction

    function automatic vpn_t page_of(logic [ADDR_W-1:0] va);
        return va[ADDR_W-1:OFS_W];
    endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  tlb_entry_t [N-1:0]   ents,
    input  vpn_t                 key,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);

    logic [N-1:0] vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign vec[g] = ents[g].valid && (ents[g].vpn == key);
    end

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

    assign any = |vec;

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(vec)) else $error("duplicate page in buffer"); // R7

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [N-1:0]     valid_vec,
    input  logic             advance,
    output logic             has_free,
    output logic [IDX_W-1:0] slot
);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx = IDX_W'(i);
        end
    end

    assign has_free = ~&valid_vec;
    assign slot     = has_free ? free_idx : ptr_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (advance && !flush) |=> (ptr_q != $past(ptr_q))) else $error("pointer stalled"); // R9

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        lk_req,
    input  logic        lk_store,
    input  logic [31:0] lk_vaddr,
    output logic        lk_hit,
    output logic        lk_miss,
    output logic [31:0] lk_paddr,
    output logic        lk_ref,
    output logic        lk_dirty,
    input  logic        fill_req,
    input  logic [19:0] fill_vpn,
    input  logic [19:0] fill_pfn
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tlb_entry_t [ENTRIES-1:0] ent_q;
    logic [ENTRIES-1:0]       valid_vec;
    logic                     look_any, fill_any, has_free, advance;
    logic [IDX_W-1:0]         look_idx, fill_idx, vic_idx, tgt_idx;
    tlb_entry_t               hit_ent;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
        assign valid_vec[g] = ent_q[g].valid;
    end

    tlb_cam #(.N(ENTRIES), .IDX_W(IDX_W)) u_look (
        .clk(clk), .rst(rst), .ents(ent_q), .key(page_of(lk_vaddr)),
        .any(look_any), .idx(look_idx)
    );

    tlb_cam #(.N(ENTRIES), .IDX_W(IDX_W)) u_fillcmp (
        .clk(clk), .rst(rst), .ents(ent_q), .key(fill_vpn),
        .any(fill_any), .idx(fill_idx)
    );

    assign advance = fill_req && !fill_any && !has_free;

    tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk(clk), .rst(rst), .flush(flush), .valid_vec(valid_vec),
        .advance(advance), .has_free(has_free), .slot(vic_idx)
    );

    assign tgt_idx = fill_any ? fill_idx : vic_idx;
    assign hit_ent = ent_q[look_idx];

    assign lk_hit   = lk_req && look_any;
    assign lk_miss  = lk_req && !look_any;
    assign lk_paddr = join_paddr(hit_ent.pfn, lk_vaddr[OFS_W-1:0]);
    assign lk_ref   = lk_hit && hit_ent.refd;
    assign lk_dirty = lk_hit && hit_ent.dirty;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
        end else if (flush) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i].valid <= 1'b0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (lk_hit && look_idx == IDX_W'(i)) begin
                    ent_q[i].refd <= 1'b1;
                    if (lk_store) ent_q[i].dirty <= 1'b1;
                end
                if (fill_req && tgt_idx == IDX_W'(i)) begin
                    ent_q[i] <= '{valid: 1'b1, vpn: fill_vpn, pfn: fill_pfn,
                                  refd: 1'b0, dirty: 1'b0};
                end
            end
        end
    end

    AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (rst)
        lk_req |-> (lk_hit ^ lk_miss)) else $error("hit/miss not exclusive"); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lk_req |-> !(lk_hit || lk_miss)) else $error("output without request"); // R2
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0)) else $error("entry survived flush"); // R10
    AST_REF_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && !fill_req && !flush) |=> ent_q[$past(look_idx)].refd) else $error("ref not set"); // R4
    AST_DIRTY_ON_STORE: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_store && !fill_req && !flush) |=> ent_q[$past(look_idx)].dirty) else $error("dirty not set"); // R5
    AST_FILL_PRESENT: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !flush) |=> (ent_q[$past(tgt_idx)].valid &&
                                  ent_q[$past(tgt_idx)].vpn == $past(fill_vpn))) else $error("fill lost"); // R6

endmodule

// File: tb/tb_tlb_fa.sv
`timescale 1ns/1ps
module tb_tlb_fa;

    logic        clk = 1'b0;
    logic        rst, flush, lk_req, lk_store, fill_req;
    logic [31:0] lk_vaddr, lk_paddr;
    logic        lk_hit, lk_miss, lk_ref, lk_dirty;
    logic [19:0] fill_vpn, fill_pfn;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tlb_fa #(.ENTRIES(8)) dut (
        .clk(clk), .rst(rst), .flush(flush), .lk_req(lk_req), .lk_store(lk_store),
        .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
        .lk_ref(lk_ref), .lk_dirty(lk_dirty), .fill_req(fill_req),
        .fill_vpn(fill_vpn), .fill_pfn(fill_pfn)
    );

    function automatic logic [19:0] va_pg(int i);  return 20'hA0000 + 20'(i) * 20'h111; endfunction
    function automatic logic [19:0] pa_fr(int i);  return 20'h50000 ^ (20'(i) * 20'h0F3); endfunction
    function automatic logic [19:0] vb_pg(int i);  return 20'h30000 + 20'(i) * 20'h0A5; endfunction
    function automatic logic [19:0] vc_pg(int i);  return 20'h70000 + 20'(i) * 20'h321; endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // lookup; exp_pfn/ref/dirty only checked when a hit is expected
    task automatic lookup(logic [19:0] vpn, logic [11:0] ofs, bit st, bit exp_hit,
                          logic [19:0] exp_pfn, bit exp_ref, bit exp_dirty, string req);
        @(negedge clk);
        lk_req = 1'b1; lk_store = st; lk_vaddr = {vpn, ofs};
        #1;
        check(lk_hit == exp_hit && lk_miss == !exp_hit, req, {lk_hit, lk_miss}, {exp_hit, !exp_hit});
        if (exp_hit) begin
            check(lk_paddr == {exp_pfn, ofs}, {req, " R1"}, lk_paddr, {exp_pfn, ofs});
            check(lk_ref == exp_ref && lk_dirty == exp_dirty, req, {lk_ref, lk_dirty}, {exp_ref, exp_dirty});
        end
        @(posedge clk); #1;
        lk_req = 1'b0; lk_store = 1'b0;
    endtask

    task automatic fill(logic [19:0] vpn, logic [19:0] pfn, bit fl);
        @(negedge clk);
        fill_req = 1'b1; fill_vpn = vpn; fill_pfn = pfn; flush = fl;
        @(posedge clk); #1;
        fill_req = 1'b0; flush = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [19:0] slot_vpn [8];
        rst = 1'b1; flush = 1'b0; lk_req = 1'b0; lk_store = 1'b0; lk_vaddr = '0;
        fill_req = 1'b0; fill_vpn = '0; fill_pfn = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R3: empty after reset
        for (int i = 0; i < 8; i++) lookup(va_pg(i), 12'h0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R3 reset miss");
        // R2: idle strobe keeps both flags low
        @(negedge clk); lk_vaddr = {va_pg(0), 12'h0}; #1;
        check(!lk_hit && !lk_miss, "R2 idle", {lk_hit, lk_miss}, 2'b00);

        // R8/R6: fill eight pages into free slots
        for (int i = 0; i < 8; i++) fill(va_pg(i), pa_fr(i), 1'b0);
        for (int i = 0; i < 8; i++) begin
            logic [11:0] o = 12'(i * 12'h155 + 12'h0FF);
            lookup(va_pg(i), o, 1'b0, 1'b1, pa_fr(i), 1'b0, 1'b0, "R6 R8 fresh hit");
            lookup(va_pg(i), ~o, 1'b1, 1'b1, pa_fr(i), 1'b1, 1'b0, "R4 ref set");
            lookup(va_pg(i), 12'hFFF, 1'b0, 1'b1, pa_fr(i), 1'b1, 1'b1, "R5 dirty set");
        end
        lookup(20'h12345, 12'h0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2 absent miss");

        // R7: refill a present page
        fill(va_pg(3), 20'hFEDCB, 1'b0);
        lookup(va_pg(3), 12'h123, 1'b0, 1'b1, 20'hFEDCB, 1'b0, 1'b0, "R7 overwrite");
        // R9: new page evicts slot 0 (pointer unused so far, refill took no slot)
        fill(20'hB0000, 20'h0BEEF, 1'b0);
        lookup(va_pg(0), 12'h0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R9 slot0 evicted");
        lookup(20'hB0000, 12'h456, 1'b0, 1'b1, 20'h0BEEF, 1'b0, 1'b0, "R9 new hit");
        for (int i = 1; i < 8; i++)
            lookup(va_pg(i), 12'h0, 1'b0, 1'b1, (i == 3) ? 20'hFEDCB : pa_fr(i), 1'b1, i != 3, "R7 R9 kept");

        // R10: flush beats concurrent fill
        fill(20'hC0000, 20'h11111, 1'b1);
        lookup(20'hC0000, 12'h0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R10 fill dropped");
        for (int i = 1; i < 8; i++) lookup(va_pg(i), 12'h0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R10 flushed");

        // R8/R9: refill, then rotate through every slot and wrap
        for (int i = 0; i < 8; i++) begin
            fill(vb_pg(i), pa_fr(i + 8), 1'b0);
            slot_vpn[i] = vb_pg(i);
        end
        for (int i = 0; i < 8; i++) lookup(vb_pg(i), 12'h7, 1'b0, 1'b1, pa_fr(i + 8), 1'b0, 1'b0, "R8 all kept");
        for (int k = 0; k < 9; k++) begin
            logic [19:0] gone = slot_vpn[k % 8];
            fill(vc_pg(k), pa_fr(k + 16), 1'b0);
            slot_vpn[k % 8] = vc_pg(k);
            lookup(gone, 12'h0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R9 rotating victim");
            lookup(vc_pg(k), 12'hABC, 1'b0, 1'b1, pa_fr(k + 16), 1'b0, 1'b0, "R9 replacement hit");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule